// File: doc/BRIEF.md
# UART Channel Command Decoder

This block sits behind one channel's command register in a dual-channel serial controller. When the host writes a byte to that register, the decoder does two things at the same clock edge. First, it may update the transmitter and receiver enable flags, depending on a guard bit in the byte. Second, it turns the 5-bit command field into either a single-cycle action pulse or a change to a persistent mode level.

The transmitter, receiver, counter/timer and reset logic consume these pulses and levels. None of that logic is part of this block.

A strap input tells the decoder whether it serves the first channel. A few commands act on the whole device, so they are honoured only on the first channel and ignored on the second. All inputs and outputs are plain control pins. No data stream crosses this block, so it has no valid/ready handshake and applies no back-pressure: every write strobe is accepted in the cycle it is presented.

Top module: `uart_cmd_decoder`

## Requirements
- R1: A write whose bit 7 is 0 leaves `tx_enable` and `rx_enable` unchanged, whatever bits 6 and 5 hold.
- R2: A write whose bit 7 is 1 loads `tx_enable` from bit 6 and `rx_enable` from bit 5. Both are visible in the cycle after the strobe.
- R3: Each command pulse is high for exactly one cycle, namely the cycle after the write strobe. At most one pulse fires per write, and an enable update and a pulse from the same write appear in the same cycle.
- R4: Command field (bits 4:0) 0x02 pulses `rx_reset_p`, 0x03 pulses `tx_reset_p`, 0x04 pulses `err_clear_p` and 0x05 pulses `brk_chg_clear_p`. Code 0x00 does nothing.
- R5: Code 0x06 pulses `brk_start_p` and 0x07 pulses `brk_stop_p`. Code 0x08 drives `rts_n` low and 0x09 drives it high, and `rts_n` holds its level until the next such write.
- R6: Code 0x0A sets `rx_timeout_mode` and 0x0C clears it. Code 0x0B pulses `mr_ptr_clear_p`.
- R7: Code 0x0D sets `err_on_load` (status accumulates when a character enters the receive FIFO). Code 0x1D clears it (status accumulates on read).
- R8: Code 0x10 pulses `xon_req_p`, 0x11 `xoff_req_p`, 0x12 `ct_start_p`, 0x13 `ct_stop_p`, 0x16 `tx_resume_p`, 0x17 `tx_pause_p`, 0x18 `xchar_cancel_p` and 0x1B `addr_stat_clear_p`.
- R9: With `chan_first` high, code 0x0E sets `power_down` and 0x0F clears it. With `chan_first` low, both codes leave `power_down` unchanged.
- R10: Code 0x1F pulses `dev_reset_p` only when `chan_first` is high. With `chan_first` low it has no effect.
- R11: Reserved codes 0x01, 0x14, 0x15, 0x19, 0x1A and 0x1C produce no pulse and change no level.
- R12: While `rst_n` is low and after it rises, both enables are 0, `rts_n` is 1, `power_down`, `rx_timeout_mode` and `err_on_load` are 0, and no pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe, one cycle per write |
| cmd_byte | input | 8 | Byte written: bit 7 guard, bit 6 tx enable, bit 5 rx enable, bits 4:0 command |
| chan_first | input | 1 | Strap: high when this decoder serves the first channel |
| tx_enable | output | 1 | Transmitter enable level |
| rx_enable | output | 1 | Receiver enable level |
| rts_n | output | 1 | Request-to-send, active low |
| rx_timeout_mode | output | 1 | Counter/timer used as receiver timeout |
| power_down | output | 1 | Power-down mode level |
| err_on_load | output | 1 | 1: status accumulates on FIFO load; 0: on FIFO read |
| rx_reset_p | output | 1 | Receiver reset pulse |
| tx_reset_p | output | 1 | Transmitter reset pulse |
| err_clear_p | output | 1 | Clear error status pulse |
| brk_chg_clear_p | output | 1 | Clear break-change interrupt pulse |
| brk_start_p | output | 1 | Start break request pulse |
| brk_stop_p | output | 1 | Stop break request pulse |
| mr_ptr_clear_p | output | 1 | Mode-register pointer to 0 pulse |
| xon_req_p | output | 1 | Send flow-on character request |
| xoff_req_p | output | 1 | Send flow-off character request |
| ct_start_p | output | 1 | Counter/timer start pulse |
| ct_stop_p | output | 1 | Counter/timer stop pulse |
| tx_resume_p | output | 1 | Transmitter resume pulse |
| tx_pause_p | output | 1 | Transmitter pause pulse |
| xchar_cancel_p | output | 1 | Cancel pending flow character pulse |
| addr_stat_clear_p | output | 1 | Clear address-recognition status pulse |
| dev_reset_p | output | 1 | Whole-device reset pulse |

## Verification
The bench sweeps all 32 command codes on each channel and checks every pulse and level in the cycle after each write.

- A decoder that ignored the guard bit would show enable flags following bits 6:5 on ordinary command writes.
- One that did not gate the device-wide codes by channel would reset the device, or toggle power-down, from the second channel.
- Back-to-back writes and a write that both changes the enables and issues a reset expose pulses that stretch to two cycles, or an enable update that lands a cycle apart from its pulse.
- Reserved codes are checked for silence on every output, so a decoder that aliased one of them onto a neighbouring code would fire a stray pulse.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam int BYTE_W   = 8;
  localparam int CODE_W   = 5;
  localparam int LOCK_POS = 7;
  localparam int TXEN_POS = 6;
  localparam int RXEN_POS = 5;

  // command field values
  localparam logic [CODE_W-1:0] C_NOP        = 5'h00;
  localparam logic [CODE_W-1:0] C_RX_RST     = 5'h02;
  localparam logic [CODE_W-1:0] C_TX_RST     = 5'h03;
  localparam logic [CODE_W-1:0] C_ERR_CLR    = 5'h04;
  localparam logic [CODE_W-1:0] C_BRKCHG_CLR = 5'h05;
  localparam logic [CODE_W-1:0] C_BRK_START  = 5'h06;
  localparam logic [CODE_W-1:0] C_BRK_STOP   = 5'h07;
  localparam logic [CODE_W-1:0] C_RTS_ON     = 5'h08;
  localparam logic [CODE_W-1:0] C_RTS_OFF    = 5'h09;
  localparam logic [CODE_W-1:0] C_TO_ON      = 5'h0A;
  localparam logic [CODE_W-1:0] C_MRPTR_CLR  = 5'h0B;
  localparam logic [CODE_W-1:0] C_TO_OFF     = 5'h0C;
  localparam logic [CODE_W-1:0] C_ACC_LOAD   = 5'h0D;
  localparam logic [CODE_W-1:0] C_PD_ON      = 5'h0E;
  localparam logic [CODE_W-1:0] C_PD_OFF     = 5'h0F;
  localparam logic [CODE_W-1:0] C_XON        = 5'h10;
  localparam logic [CODE_W-1:0] C_XOFF       = 5'h11;
  localparam logic [CODE_W-1:0] C_CT_START   = 5'h12;
  localparam logic [CODE_W-1:0] C_CT_STOP    = 5'h13;
  localparam logic [CODE_W-1:0] C_TX_RESUME  = 5'h16;
  localparam logic [CODE_W-1:0] C_TX_PAUSE   = 5'h17;
  localparam logic [CODE_W-1:0] C_XCANCEL    = 5'h18;
  localparam logic [CODE_W-1:0] C_ADDR_CLR   = 5'h1B;
  localparam logic [CODE_W-1:0] C_ACC_READ   = 5'h1D;
  localparam logic [CODE_W-1:0] C_DEV_RST    = 5'h1F;

  // action vector layout: pulses first, then level set/clear requests
  localparam int A_RX_RST     = 0;
  localparam int A_TX_RST     = 1;
  localparam int A_ERR_CLR    = 2;
  localparam int A_BRKCHG_CLR = 3;
  localparam int A_BRK_START  = 4;
  localparam int A_BRK_STOP   = 5;
  localparam int A_MRPTR_CLR  = 6;
  localparam int A_XON        = 7;
  localparam int A_XOFF       = 8;
  localparam int A_CT_START   = 9;
  localparam int A_CT_STOP    = 10;
  localparam int A_TX_RESUME  = 11;
  localparam int A_TX_PAUSE   = 12;
  localparam int A_XCANCEL    = 13;
  localparam int A_ADDR_CLR   = 14;
  localparam int A_DEV_RST    = 15;
  localparam int NUM_PULSE    = 16;

  localparam int A_RTS_ON     = NUM_PULSE + 0;
  localparam int A_RTS_OFF    = NUM_PULSE + 1;
  localparam int A_TO_ON      = NUM_PULSE + 2;
  localparam int A_TO_OFF     = NUM_PULSE + 3;
  localparam int A_PD_ON      = NUM_PULSE + 4;
  localparam int A_PD_OFF     = NUM_PULSE + 5;
  localparam int A_ACC_LOAD   = NUM_PULSE + 6;
  localparam int A_ACC_READ   = NUM_PULSE + 7;
  localparam int NUM_LEVEL_ACT = 8;
  localparam int NUM_ACT      = NUM_PULSE + NUM_LEVEL_ACT;

  typedef logic [NUM_ACT-1:0]   act_vec_t;
  typedef logic [NUM_PULSE-1:0] pulse_vec_t;

  // codes that act on the whole device and live only in the first channel
  function automatic logic is_global_code(input logic [CODE_W-1:0] c);
    return (c == C_PD_ON) || (c == C_PD_OFF) || (c == C_DEV_RST);
  endfunction

endpackage

// File: rtl/cmd_field_decode.sv
module cmd_field_decode
  import uart_cmd_pkg::*;
#(
  parameter bit GATE_GLOBAL = 1'b1
) (
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  logic              first_chan,
  output act_vec_t          act
);

  logic allowed;

  generate
    if (GATE_GLOBAL) begin : g_gate
      assign allowed = valid && (first_chan || !is_global_code(code));
    end else begin : g_nogate
      assign allowed = valid;
    end
  endgenerate

  always_comb begin
    act = '0;
    if (allowed) begin
      case (code)
        C_RX_RST:     act[A_RX_RST]     = 1'b1;
        C_TX_RST:     act[A_TX_RST]     = 1'b1;
        C_ERR_CLR:    act[A_ERR_CLR]    = 1'b1;
        C_BRKCHG_CLR: act[A_BRKCHG_CLR] = 1'b1;
        C_BRK_START:  act[A_BRK_START]  = 1'b1;
        C_BRK_STOP:   act[A_BRK_STOP]   = 1'b1;
        C_RTS_ON:     act[A_RTS_ON]     = 1'b1;
        C_RTS_OFF:    act[A_RTS_OFF]    = 1'b1;
        C_TO_ON:      act[A_TO_ON]      = 1'b1;
        C_MRPTR_CLR:  act[A_MRPTR_CLR]  = 1'b1;
        C_TO_OFF:     act[A_TO_OFF]     = 1'b1;
        C_ACC_LOAD:   act[A_ACC_LOAD]   = 1'b1;
        C_PD_ON:      act[A_PD_ON]      = 1'b1;
        C_PD_OFF:     act[A_PD_OFF]     = 1'b1;
        C_XON:        act[A_XON]        = 1'b1;
        C_XOFF:       act[A_XOFF]       = 1'b1;
        C_CT_START:   act[A_CT_START]   = 1'b1;
        C_CT_STOP:    act[A_CT_STOP]    = 1'b1;
        C_TX_RESUME:  act[A_TX_RESUME]  = 1'b1;
        C_TX_PAUSE:   act[A_TX_PAUSE]   = 1'b1;
        C_XCANCEL:    act[A_XCANCEL]    = 1'b1;
        C_ADDR_CLR:   act[A_ADDR_CLR]   = 1'b1;
        C_ACC_READ:   act[A_ACC_READ]   = 1'b1;
        C_DEV_RST:    act[A_DEV_RST]    = 1'b1;
        default:      act = '0;  // no-op and reserved codes
      endcase
    end
  end

endmodule

// File: rtl/chan_enable_reg.sv
module chan_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic unlock,
  input  logic tx_bit,
  input  logic rx_bit,
  output logic tx_en,
  output logic rx_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
    end else if (wr && unlock) begin
      tx_en <= tx_bit;
      rx_en <= rx_bit;
    end
  end

  // R1
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !unlock) |=> ($stable(tx_en) && $stable(rx_en)));

  // R2
  unlocked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && unlock) |=> (tx_en == $past(tx_bit) && rx_en == $past(rx_bit)));

endmodule

// File: rtl/chan_mode_reg.sv
module chan_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_on,
  input  logic rts_off,
  input  logic to_on,
  input  logic to_off,
  input  logic pd_on,
  input  logic pd_off,
  input  logic acc_load,
  input  logic acc_read,
  output logic rts_n,
  output logic rx_timeout_mode,
  output logic power_down,
  output logic err_on_load
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n           <= 1'b1;
      rx_timeout_mode <= 1'b0;
      power_down      <= 1'b0;
      err_on_load     <= 1'b0;
    end else begin
      if (rts_on)        rts_n <= 1'b0;
      else if (rts_off)  rts_n <= 1'b1;
      if (to_on)         rx_timeout_mode <= 1'b1;
      else if (to_off)   rx_timeout_mode <= 1'b0;
      if (pd_on)         power_down <= 1'b1;
      else if (pd_off)   power_down <= 1'b0;
      if (acc_load)      err_on_load <= 1'b1;
      else if (acc_read) err_on_load <= 1'b0;
    end
  end

  // R5
  rts_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rts_n) |-> $past(rts_on || rts_off));

  // R7
  acc_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_on_load) |-> $past(acc_load || acc_read));

  // R6
  to_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_timeout_mode) |-> $past(to_on || to_off));

endmodule

// File: rtl/uart_cmd_decoder.sv
module uart_cmd_decoder
  import uart_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              chan_first,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              rts_n,
  output logic              rx_timeout_mode,
  output logic              power_down,
  output logic              err_on_load,
  output logic              rx_reset_p,
  output logic              tx_reset_p,
  output logic              err_clear_p,
  output logic              brk_chg_clear_p,
  output logic              brk_start_p,
  output logic              brk_stop_p,
  output logic              mr_ptr_clear_p,
  output logic              xon_req_p,
  output logic              xoff_req_p,
  output logic              ct_start_p,
  output logic              ct_stop_p,
  output logic              tx_resume_p,
  output logic              tx_pause_p,
  output logic              xchar_cancel_p,
  output logic              addr_stat_clear_p,
  output logic              dev_reset_p
);

  act_vec_t   act;
  pulse_vec_t pulse_q;

  cmd_field_decode #(.GATE_GLOBAL(1'b1)) u_dec (
    .valid      (cmd_wr),
    .code       (cmd_byte[CODE_W-1:0]),
    .first_chan (chan_first),
    .act        (act)
  );

  chan_enable_reg u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cmd_wr),
    .unlock (cmd_byte[LOCK_POS]),
    .tx_bit (cmd_byte[TXEN_POS]),
    .rx_bit (cmd_byte[RXEN_POS]),
    .tx_en  (tx_enable),
    .rx_en  (rx_enable)
  );

  chan_mode_reg u_mode (
    .clk             (clk),
    .rst_n           (rst_n),
    .rts_on          (act[A_RTS_ON]),
    .rts_off         (act[A_RTS_OFF]),
    .to_on           (act[A_TO_ON]),
    .to_off          (act[A_TO_OFF]),
    .pd_on           (act[A_PD_ON]),
    .pd_off          (act[A_PD_OFF]),
    .acc_load        (act[A_ACC_LOAD]),
    .acc_read        (act[A_ACC_READ]),
    .rts_n           (rts_n),
    .rx_timeout_mode (rx_timeout_mode),
    .power_down      (power_down),
    .err_on_load     (err_on_load)
  );

  // one flop per pulse; each clears itself the cycle after
  generate
    for (genvar i = 0; i < NUM_PULSE; i++) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q[i] <= 1'b0;
        else        pulse_q[i] <= act[i];
      end
    end
  endgenerate

  assign rx_reset_p        = pulse_q[A_RX_RST];
  assign tx_reset_p        = pulse_q[A_TX_RST];
  assign err_clear_p       = pulse_q[A_ERR_CLR];
  assign brk_chg_clear_p   = pulse_q[A_BRKCHG_CLR];
  assign brk_start_p       = pulse_q[A_BRK_START];
  assign brk_stop_p        = pulse_q[A_BRK_STOP];
  assign mr_ptr_clear_p    = pulse_q[A_MRPTR_CLR];
  assign xon_req_p         = pulse_q[A_XON];
  assign xoff_req_p        = pulse_q[A_XOFF];
  assign ct_start_p        = pulse_q[A_CT_START];
  assign ct_stop_p         = pulse_q[A_CT_STOP];
  assign tx_resume_p       = pulse_q[A_TX_RESUME];
  assign tx_pause_p        = pulse_q[A_TX_PAUSE];
  assign xchar_cancel_p    = pulse_q[A_XCANCEL];
  assign addr_stat_clear_p = pulse_q[A_ADDR_CLR];
  assign dev_reset_p       = pulse_q[A_DEV_RST];

  // R3
  pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) |-> $past(cmd_wr));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q));

  // R3
  no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (pulse_q == '0));

  // R10
  second_chan_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !chan_first) |=> !dev_reset_p);

  // R9
  second_chan_pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !chan_first) |=> $stable(power_down));

endmodule

// File: tb/uart_cmd_decoder_bench.sv
module uart_cmd_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       chan_first = 1'b1;

  logic tx_enable, rx_enable, rts_n, rx_timeout_mode, power_down, err_on_load;
  logic rx_reset_p, tx_reset_p, err_clear_p, brk_chg_clear_p, brk_start_p, brk_stop_p;
  logic mr_ptr_clear_p, xon_req_p, xoff_req_p, ct_start_p, ct_stop_p, tx_resume_p;
  logic tx_pause_p, xchar_cancel_p, addr_stat_clear_p, dev_reset_p;

  always #4 clk = ~clk;  // 125 MHz

  uart_cmd_decoder u_uart_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .chan_first(chan_first),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .rts_n(rts_n),
    .rx_timeout_mode(rx_timeout_mode), .power_down(power_down),
    .err_on_load(err_on_load),
    .rx_reset_p(rx_reset_p), .tx_reset_p(tx_reset_p), .err_clear_p(err_clear_p),
    .brk_chg_clear_p(brk_chg_clear_p), .brk_start_p(brk_start_p),
    .brk_stop_p(brk_stop_p), .mr_ptr_clear_p(mr_ptr_clear_p),
    .xon_req_p(xon_req_p), .xoff_req_p(xoff_req_p), .ct_start_p(ct_start_p),
    .ct_stop_p(ct_stop_p), .tx_resume_p(tx_resume_p), .tx_pause_p(tx_pause_p),
    .xchar_cancel_p(xchar_cancel_p), .addr_stat_clear_p(addr_stat_clear_p),
    .dev_reset_p(dev_reset_p)
  );

  // observed pulse bundle: bit 15 rx_reset ... bit 0 dev_reset
  wire [15:0] pulses_seen = {rx_reset_p, tx_reset_p, err_clear_p, brk_chg_clear_p,
                             brk_start_p, brk_stop_p, mr_ptr_clear_p, xon_req_p,
                             xoff_req_p, ct_start_p, ct_stop_p, tx_resume_p,
                             tx_pause_p, xchar_cancel_p, addr_stat_clear_p, dev_reset_p};
  wire [5:0] levels_seen = {tx_enable, rx_enable, rts_n, rx_timeout_mode,
                            power_down, err_on_load};

  typedef struct {
    int          due;
    logic [15:0] pulses;
    logic [5:0]  levels;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   bad = 0;
  bit   done = 1'b0;

  // bench model of the persistent state
  logic m_tx = 0, m_rx = 0, m_rts_n = 1, m_to = 0, m_pd = 0, m_acc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] pulse_for(input logic [4:0] c, input logic first);
    case (c)
      5'h02: return 16'h8000;
      5'h03: return 16'h4000;
      5'h04: return 16'h2000;
      5'h05: return 16'h1000;
      5'h06: return 16'h0800;
      5'h07: return 16'h0400;
      5'h0B: return 16'h0200;
      5'h10: return 16'h0100;
      5'h11: return 16'h0080;
      5'h12: return 16'h0040;
      5'h13: return 16'h0020;
      5'h16: return 16'h0010;
      5'h17: return 16'h0008;
      5'h18: return 16'h0004;
      5'h1B: return 16'h0002;
      5'h1F: return first ? 16'h0001 : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_for(input logic [4:0] c);
    case (c)
      5'h00, 5'h02, 5'h03, 5'h04, 5'h05: return "R4";
      5'h06, 5'h07, 5'h08, 5'h09: return "R5";
      5'h0A, 5'h0B, 5'h0C: return "R6";
      5'h0D, 5'h1D: return "R7";
      5'h0E, 5'h0F: return "R9";
      5'h1F: return "R10";
      5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h18, 5'h1B: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [5:0] model_levels();
    return {m_tx, m_rx, m_rts_n, m_to, m_pd, m_acc};
  endfunction

  task automatic push(input logic [15:0] p, input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.pulses = p;
    e.levels = model_levels();
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    cmd_wr = 1'b0;
    push(16'h0000, tag);
  endtask

  task automatic wr(input logic [7:0] b, input logic first, input string tag_in);
    logic [4:0] c;
    string tag;
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_byte = b;
    chan_first = first;
    c = b[4:0];
    tag = (tag_in == "") ? tag_for(c) : tag_in;
    if (b[7]) begin
      m_tx = b[6];
      m_rx = b[5];
    end
    case (c)
      5'h08: m_rts_n = 1'b0;
      5'h09: m_rts_n = 1'b1;
      5'h0A: m_to = 1'b1;
      5'h0C: m_to = 1'b0;
      5'h0D: m_acc = 1'b1;
      5'h1D: m_acc = 1'b0;
      5'h0E: if (first) m_pd = 1'b1;
      5'h0F: if (first) m_pd = 1'b0;
      default: ;
    endcase
    push(pulse_for(c, first), tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pulses_seen !== e.pulses || levels_seen !== e.levels) begin
        bad++;
        $display("FAIL %s cyc=%0d: pulses=%h levels=%b expected pulses=%h levels=%b",
                 e.tag, cyc, pulses_seen, levels_seen, e.pulses, e.levels);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // R12: outputs while in reset
    repeat (2) @(negedge clk);
    checks++;
    if (pulses_seen !== 16'h0 || levels_seen !== 6'b001000) begin
      bad++;
      $display("FAIL R12 in reset: pulses=%h levels=%b expected pulses=0000 levels=001000",
               pulses_seen, levels_seen);
    end
    rst_n = 1'b1;
    idle("R12");
    idle("R12");

    // R1: guard bit clear, enable bits set -> no change
    wr(8'h60, 1'b1, "R1");
    idle("R1");
    // R2: guard set loads both
    wr(8'hE0, 1'b1, "R2");
    wr(8'hC0, 1'b1, "R2");
    wr(8'hA0, 1'b1, "R2");
    // R1: guard clear with bits that would disable rx
    wr(8'h40, 1'b1, "R1");
    idle("R1");

    // R3: enable change and reset pulse from the same write, then back-to-back
    wr(8'hC2, 1'b1, "R3");
    wr(8'h03, 1'b1, "R3");
    wr(8'h04, 1'b1, "R3");
    idle("R3");

    // sweep all codes on the first channel, one idle between writes
    for (int k = 0; k < 32; k++) begin
      wr({3'b000, 5'(k)}, 1'b1, "");
      idle("R3");
    end
    // sweep all codes on the second channel back to back
    for (int k = 0; k < 32; k++) begin
      wr({3'b000, 5'(k)}, 1'b0, "");
    end
    idle("R3");

    // R9: power-down set on first, second channel cannot clear or set it
    wr(8'h0E, 1'b1, "R9");
    wr(8'h0F, 1'b0, "R9");
    idle("R9");
    wr(8'h0F, 1'b1, "R9");
    wr(8'h0E, 1'b0, "R9");
    // R10: device reset only on first
    wr(8'h1F, 1'b0, "R10");
    wr(8'h1F, 1'b1, "R10");
    idle("R10");
    // R7 / R5 ordering checks
    wr(8'h0D, 1'b0, "R7");
    wr(8'h1D, 1'b0, "R7");
    wr(8'h08, 1'b0, "R5");
    idle("R5");
    wr(8'h09, 1'b1, "R5");
    // R11: reserved codes with guard set still update enables but nothing else
    wr(8'hE1, 1'b1, "R11");
    wr(8'h9C, 1'b1, "R11");
    idle("R11");
    idle("R11");

    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule